// File: doc/BRIEF.md
# Cascadable Configuration Bitstream Streamer

This block is the read side of a configuration store that feeds a stored bitstream to a programmable-logic device. The image sits in an internal byte array fixed by a parameter. An address counter and a bit counter walk through it, one step per rising edge of the configuration clock. In byte-wide mode every clock presents a whole byte on eight data pins. In serial mode every clock presents one bit on data pin 0, and the other seven pins float.

Several units can share one clock and one data bus. Each unit drives the bus only while its enable input is low, its output-enable/reset input is high and unread data is left. Once the last word has been presented, the unit pulls its enable output low, which starts the next unit in the chain. Clocks that arrive after the image is used up have no effect. A low level on the output-enable/reset input rewinds the unit at the next clock edge.

Top module: `cfg_streamer`

## Requirements
- R1: While `oe_rst_n` is low, a rising clock edge sets the position to byte 0, bit 0 and sets `en_out_n` high. With `oe_rst_n` low, `data_oe` is 0.
- R2: When `mode_byte`=0, the bits of each byte go out on `data_o[0]`, bit 7 first, with a new bit after each rising edge. `data_oe` is 8'h01 while the unit drives.
- R3: In serial mode the byte address advances after the eighth bit of a byte has been presented.
- R4: When `mode_byte`=1, byte i of `IMAGE` (bits 8i+7..8i) appears on `data_o[7:0]` with `data_oe`=8'hFF. Byte i+1 follows after the next rising edge.
- R5: While `en_in_n` is high, clock edges do not move the position and `data_oe` is 0.
- R6: After the last byte (or bit) has been presented, the unit stops driving (`data_oe`=0) and `en_out_n` goes low while `en_in_n` is low. Further clocks leave this state unchanged.
- R7: `en_out_n` stays low until a reset, as long as `en_in_n` stays low. It reads high whenever `en_in_n` is high.
- R8: When a unit's `en_out_n` feeds the next unit's `en_in_n`, the next unit presents its byte 0 in the cycle in which the first unit stops driving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration clock; the position advances on its rising edge |
| oe_rst_n | input | 1 | Output enable when high, synchronous rewind when low |
| en_in_n | input | 1 | Active-low unit enable from the previous stage |
| mode_byte | input | 1 | 1 = byte-wide mode, 0 = serial mode |
| en_out_n | output | 1 | Active-low enable for the next unit, low once the image is used up |
| data_o | output | 8 | Tri-stated data pins; only pin 0 carries data in serial mode |
| data_oe | output | 8 | Per-pin drive enable that mirrors the tri-state control |

## Verification
The data and drive-enable outputs depend combinationally on the registered position. A value is therefore due in the same cycle as the clock edge that produced it, and its receiver would sample it on the next rising edge. The bench changes inputs just after a falling edge, samples a couple of nanoseconds later and moves on one falling edge at a time, so each sample sees the result of exactly one rising edge. `en_out_n` combines the registered position with the enable input. The bench therefore expects it to follow an enable change within that same sample and to follow exhaustion in the sample after the last byte. Reset effects are checked only after the edge that takes the reset.

// File: rtl/cfs_pkg.sv
// Package: shared mode type and constants for the configuration streamer.
// Assumes byte-wide storage; serial mode walks each byte from bit 7 down.
package cfs_pkg;
    typedef enum logic {
        MODE_SERIAL = 1'b0,
        MODE_BYTE   = 1'b1
    } cfs_mode_e;

    localparam int BYTE_W   = 8;
    localparam int BITIDX_W = 3;
endpackage

// File: rtl/cfs_pos_ctr.sv
// Module: position counter. Holds the byte address and the bit index in the
// current byte, and flags when every stored byte has been presented.
// Assumes: step is only raised while the unit is allowed to advance.
module cfs_pos_ctr #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         step,
    input  cfs_pkg::cfs_mode_e           mode,
    output logic [AW-1:0]                addr,
    output logic [cfs_pkg::BITIDX_W-1:0] bitpos,
    output logic                         exhausted
);
    import cfs_pkg::*;

    localparam logic [AW-1:0]       LAST_ADDR = AW'(DEPTH);
    localparam logic [BITIDX_W-1:0] LAST_BIT  = '1;

    // Purpose: rewind on reset, otherwise advance one bit or one byte per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            bitpos <= '0;
        end else if (step) begin
            if (mode == MODE_BYTE || bitpos == LAST_BIT) begin
                addr   <= addr + 1'b1;
                bitpos <= '0;
            end else begin
                bitpos <= bitpos + 1'b1;
            end
        end
    end

    // Purpose: flag that the whole image has been presented.
    always_comb exhausted = (addr == LAST_ADDR);

    assert_rewind_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (addr == '0 && bitpos == '0));

    assert_serial_byte_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode == MODE_SERIAL && bitpos == LAST_BIT) |=>
            (addr == $past(addr) + 1'b1 && bitpos == '0));

    assert_addr_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        addr <= LAST_ADDR);
endmodule

// File: rtl/cfs_image_rom.sv
// Module: image store. Unpacks the IMAGE parameter into a byte array and
// reads the byte at the given address. Past the end it reads zero.
// Assumes: byte i of the image sits at IMAGE[8i+7:8i].
module cfs_image_rom #(
    parameter int                   DEPTH = 16,
    parameter int                   AW    = $clog2(DEPTH + 1),
    parameter logic [DEPTH*8-1:0]   IMAGE = {DEPTH{8'hA5}}
) (
    input  logic [AW-1:0] addr,
    output logic [7:0]    rd_byte
);
    logic [7:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_unpack
        assign mem[g] = IMAGE[g*8 +: 8];
    end

    // Purpose: select the addressed byte, zero when out of range.
    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (addr == AW'(i)) rd_byte = mem[i];
        end
    end
endmodule

// File: rtl/cfs_out_stage.sv
// Module: output stage. Forms the pin values for the current mode and
// floats every pin that is not driven.
// Assumes: the bit index counts 0..7 and bit 7 of a byte goes out first.
module cfs_out_stage (
    input  logic                         drive,
    input  cfs_pkg::cfs_mode_e           mode,
    input  logic [7:0]                   rd_byte,
    input  logic [cfs_pkg::BITIDX_W-1:0] bitpos,
    output wire  [7:0]                   data_o,
    output logic [7:0]                   data_oe
);
    import cfs_pkg::*;

    logic [7:0] pin_val;
    logic       ser_bit;

    // Purpose: pick the serial bit, most significant first.
    always_comb ser_bit = rd_byte[3'd7 - bitpos];

    // Purpose: value and per-pin enable for the active mode.
    always_comb begin
        if (mode == MODE_BYTE) begin
            pin_val = rd_byte;
            data_oe = drive ? 8'hFF : 8'h00;
        end else begin
            pin_val = {7'b0, ser_bit};
            data_oe = drive ? 8'h01 : 8'h00;
        end
    end

    for (genvar p = 0; p < 8; p++) begin : g_pin
        assign data_o[p] = data_oe[p] ? pin_val[p] : 1'bz;
    end
endmodule

// File: rtl/cfg_streamer.sv
// Module: cascadable configuration bitstream streamer (top).
// Streams IMAGE out one bit or one byte per rising edge of cclk. It
// drives the shared bus only while enabled and data remains, and hands
// over through en_out_n once the image is used up.
// Assumes: oe_rst_n is a synchronous, active-low rewind and output enable.
module cfg_streamer #(
    parameter int                 DEPTH = 16,
    parameter logic [DEPTH*8-1:0] IMAGE = {DEPTH{8'hA5}}
) (
    input  logic       cclk,
    input  logic       oe_rst_n,
    input  logic       en_in_n,
    input  logic       mode_byte,
    output logic       en_out_n,
    output wire  [7:0] data_o,
    output logic [7:0] data_oe
);
    import cfs_pkg::*;

    localparam int AW = $clog2(DEPTH + 1);

    cfs_mode_e            mode;
    logic [AW-1:0]        addr;
    logic [BITIDX_W-1:0]  bitpos;
    logic                 exhausted;
    logic                 step;
    logic [7:0]           rd_byte;

    // Purpose: decode the mode pin.
    always_comb mode = mode_byte ? MODE_BYTE : MODE_SERIAL;

    // Purpose: advance and drive only while enabled, out of reset and with data left.
    always_comb step = oe_rst_n && !en_in_n && !exhausted;

    // Purpose: pass the enable on once the image has been used up.
    always_comb en_out_n = !(exhausted && !en_in_n);

    cfs_pos_ctr #(.DEPTH(DEPTH), .AW(AW)) u_pos (
        .clk      (cclk),
        .rst_n    (oe_rst_n),
        .step     (step),
        .mode     (mode),
        .addr     (addr),
        .bitpos   (bitpos),
        .exhausted(exhausted)
    );

    cfs_image_rom #(.DEPTH(DEPTH), .AW(AW), .IMAGE(IMAGE)) u_rom (
        .addr   (addr),
        .rd_byte(rd_byte)
    );

    cfs_out_stage u_out (
        .drive  (step),
        .mode   (mode),
        .rd_byte(rd_byte),
        .bitpos (bitpos),
        .data_o (data_o),
        .data_oe(data_oe)
    );

    assert_hold_when_disabled_R5: assert property (@(posedge cclk) disable iff (!oe_rst_n)
        (oe_rst_n && en_in_n) |=> ($stable(addr) && $stable(bitpos)));

    assert_quiet_after_handoff_R6: assert property (@(posedge cclk) disable iff (!oe_rst_n)
        !en_out_n |-> (data_oe == 8'h00));

    assert_handoff_sticky_R7: assert property (@(posedge cclk) disable iff (!oe_rst_n)
        (!en_out_n && !en_in_n) |=> (en_in_n || !en_out_n));

    assert_serial_pins_R2: assert property (@(posedge cclk) disable iff (!oe_rst_n)
        (mode == MODE_SERIAL) |-> (data_oe[7:1] == 7'b0));
endmodule

// File: tb/cfg_streamer_tb.sv
// Bench: table-driven byte-mode walk, then directed serial, reset and chain tests.
module cfg_streamer_tb_top;
    localparam int               A_DEPTH = 4;
    localparam logic [31:0]      A_IMG   = {8'h96, 8'h0F, 8'h5A, 8'hC3};
    localparam int               B_DEPTH = 2;
    localparam logic [15:0]      B_IMG   = {8'h7E, 8'hE1};

    // Vector fields: {en_in_n, expect_drive, expect_en_out_n, expect_byte}
    localparam logic [10:0] BYTE_VEC [8] = '{
        {1'b0, 1'b1, 1'b1, 8'hC3},
        {1'b0, 1'b1, 1'b1, 8'h5A},
        {1'b1, 1'b0, 1'b1, 8'h00},
        {1'b0, 1'b1, 1'b1, 8'h0F},
        {1'b0, 1'b1, 1'b1, 8'h96},
        {1'b0, 1'b0, 1'b0, 8'h00},
        {1'b0, 1'b0, 1'b0, 8'h00},
        {1'b1, 1'b0, 1'b1, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_a_n = 1'b0;
    logic       rst_b_n = 1'b0;
    logic       en_n = 1'b1;
    logic       mode_byte = 1'b1;
    logic       a_ceo_n, b_ceo_n;
    wire  [7:0] a_data, b_data;
    logic [7:0] a_oe, b_oe;
    int         n_tests = 0;
    int         n_fail  = 0;
    bit         done    = 1'b0;

    always #10 clk = ~clk;

    cfg_streamer #(.DEPTH(A_DEPTH), .IMAGE(A_IMG)) dut_i (
        .cclk(clk), .oe_rst_n(rst_a_n), .en_in_n(en_n), .mode_byte(mode_byte),
        .en_out_n(a_ceo_n), .data_o(a_data), .data_oe(a_oe)
    );

    cfg_streamer #(.DEPTH(B_DEPTH), .IMAGE(B_IMG)) next_i (
        .cclk(clk), .oe_rst_n(rst_b_n), .en_in_n(a_ceo_n), .mode_byte(mode_byte),
        .en_out_n(b_ceo_n), .data_o(b_data), .data_oe(b_oe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Move one falling edge on (passes one rising edge), then settle.
    task automatic next_sample();
        @(negedge clk);
        #2;
    endtask

    initial begin : watchdog
        #(20 * 20000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        next_sample();
        next_sample();
        // R1: reset state
        check("R1 oe in reset", a_oe, 8'h00);
        check("R1 en_out_n in reset", {7'b0, a_ceo_n}, 8'h01);

        // Byte-mode table walk (R4, R5, R6, R7)
        @(negedge clk);
        rst_a_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            en_n = BYTE_VEC[k][10];
            #2;
            check((k == 2) ? "R5 pause" : (k >= 5 && k <= 6) ? "R6 exhausted" :
                  (k == 7) ? "R7 enable dropped" : "R4 byte",
                  a_oe, BYTE_VEC[k][9] ? 8'hFF : 8'h00);
            check((k >= 5) ? "R7 en_out_n" : "R6 en_out_n early",
                  {7'b0, a_ceo_n}, {7'b0, BYTE_VEC[k][8]});
            if (BYTE_VEC[k][9]) check("R4 byte value", a_data, BYTE_VEC[k][7:0]);
            @(negedge clk);
        end

        // R7: en_out_n low again when enabled, cleared by reset
        en_n = 1'b0;
        #2;
        check("R7 still handed off", {7'b0, a_ceo_n}, 8'h00);
        rst_a_n = 1'b0;
        #2;
        check("R1 oe low during reset", a_oe, 8'h00);
        next_sample();
        check("R1 en_out_n after reset edge", {7'b0, a_ceo_n}, 8'h01);
        @(negedge clk);
        rst_a_n = 1'b1;
        #2;
        check("R1 rewound to byte 0", a_data, 8'hC3);

        // Serial mode: R2, R3, R6
        @(negedge clk);
        rst_a_n = 1'b0;
        mode_byte = 1'b0;
        @(negedge clk);
        rst_a_n = 1'b1;
        #2;
        for (int k = 0; k < 32; k++) begin
            check("R2 serial oe", a_oe, 8'h01);
            check((k % 8 == 0) ? "R3 first bit of next byte" : "R2 serial bit",
                  {7'b0, a_data[0]}, {7'b0, A_IMG[(k / 8) * 8 + 7 - (k % 8)]});
            next_sample();
        end
        check("R6 serial done oe", a_oe, 8'h00);
        check("R6 serial en_out_n", {7'b0, a_ceo_n}, 8'h00);

        // R8: chain handoff in byte mode
        @(negedge clk);
        rst_a_n = 1'b0;
        rst_b_n = 1'b0;
        mode_byte = 1'b1;
        @(negedge clk);
        rst_a_n = 1'b1;
        rst_b_n = 1'b1;
        #2;
        for (int k = 0; k < 4; k++) begin
            check("R8 next idle while first streams", b_oe, 8'h00);
            next_sample();
        end
        check("R8 first stopped", a_oe, 8'h00);
        check("R8 next drives", b_oe, 8'hFF);
        check("R8 next byte 0", b_data, 8'hE1);
        next_sample();
        check("R8 next byte 1", b_data, 8'h7E);
        next_sample();
        check("R6 chain end oe", b_oe, 8'h00);
        check("R6 chain end en_out_n", {7'b0, b_ceo_n}, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule